// File: doc/BRIEF.md
# Conditional branch evaluator

This block resolves one-word relative branch instructions. Each cycle it takes a 16-bit instruction word, the address of the word that follows the branch (the sequential program counter), and the four condition flags N, Z, V and C. It reports whether the word is one of the branch kinds it knows, whether the branch is taken, and the destination address.

The upper byte of the word selects the branch kind. The lower byte is a signed offset counted in words. It is doubled and added to the sequential address, and the sum wraps modulo 2^16. Seven kinds are recognised:

- the unconditional branch;
- equal and not-equal;
- signed less-than and signed greater-than;
- unsigned higher and unsigned lower.

The result is registered, so the outputs show the evaluation of the inputs sampled at the previous rising clock edge. A fetch unit uses the result as the next program counter.

Top module: `branch_eval`

## Requirements
- R1: While `rst_n` is low, `taken_o` and `hit_o` are 0 and `target_o` is 0.
- R2: `hit_o` is 1 only for upper bytes 0x01, 0x02, 0x03, 0x05, 0x06, 0x82 and 0x87. For any other upper byte, `taken_o` is 0 and `target_o` equals the sequential address.
- R3: Upper byte 0x01 (unconditional) is taken for every flag value. `flags_i` is {N,Z,V,C}, with N in bit 3 and C in bit 0.
- R4: Upper byte 0x03 (equal) is taken when Z is 1. Upper byte 0x02 (not-equal) is taken when Z is 0.
- R5: Upper byte 0x05 (signed less-than) is taken when N xor V is 1. Upper byte 0x06 (signed greater-than) is taken when Z or (N xor V) is 0. After a compare of a signed smaller value against a larger one, these branches follow the signed order.
- R6: Upper byte 0x82 (unsigned higher) is taken when C and Z are both 0. Upper byte 0x87 (unsigned lower) is taken when C is 1. They follow unsigned order, including 32767 against 32768 and 0 against 65535.
- R7: For a recognised branch, `target_o` is the sequential address plus twice the sign-extended low byte. Bytes 0x00 to 0x7F go forward and 0x80 to 0xFF go backward. Byte 0xFF yields the address of the branch itself (sequential address minus 2).
- R8: The destination arithmetic wraps modulo 2^16 in both directions.
- R9: The outputs change exactly one rising clock edge after the inputs they reflect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word to evaluate |
| seq_pc_i | input | 16 | Address of the word after the branch |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| taken_o | output | 1 | Branch is recognised and its condition holds |
| hit_o | output | 1 | Word is a recognised branch |
| target_o | output | 16 | Branch destination, or the sequential address on a miss |

## Verification
The hardest cases to reach are flag nibbles that come from a real compare at the point where signed and unsigned order disagree, such as 32767 against 32768 or 0 against 65535. A hand-picked nibble would not show that the right flag combination was wired to each kind. The bench therefore derives N, Z, V and C by subtracting operand pairs in both orders and feeds the resulting nibble with each comparison branch. It also sweeps all 256 offsets, the self-branch byte and wrap-around at both ends of the address space.

// File: rtl/branch_eval_pkg.sv
`timescale 1ns/1ps
package branch_eval_pkg;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_ALWAYS,
    KIND_EQ,
    KIND_NE,
    KIND_SLT,
    KIND_SGT,
    KIND_UHI,
    KIND_ULO
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccodes_t;

  localparam logic [7:0] OPB_ALWAYS = 8'h01;
  localparam logic [7:0] OPB_NE     = 8'h02;
  localparam logic [7:0] OPB_EQ     = 8'h03;
  localparam logic [7:0] OPB_SLT    = 8'h05;
  localparam logic [7:0] OPB_SGT    = 8'h06;
  localparam logic [7:0] OPB_UHI    = 8'h82;
  localparam logic [7:0] OPB_ULO    = 8'h87;

  function automatic br_kind_e kind_of(input logic [7:0] opb);
    unique case (opb)
      OPB_ALWAYS: kind_of = KIND_ALWAYS;
      OPB_NE:     kind_of = KIND_NE;
      OPB_EQ:     kind_of = KIND_EQ;
      OPB_SLT:    kind_of = KIND_SLT;
      OPB_SGT:    kind_of = KIND_SGT;
      OPB_UHI:    kind_of = KIND_UHI;
      OPB_ULO:    kind_of = KIND_ULO;
      default:    kind_of = KIND_NONE;
    endcase
  endfunction

  function automatic logic cond_holds(input br_kind_e k, input ccodes_t f);
    logic lt;
    lt = f.n ^ f.v;
    unique case (k)
      KIND_ALWAYS: cond_holds = 1'b1;
      KIND_EQ:     cond_holds = f.z;
      KIND_NE:     cond_holds = ~f.z;
      KIND_SLT:    cond_holds = lt;
      KIND_SGT:    cond_holds = ~(f.z | lt);
      KIND_UHI:    cond_holds = ~(f.c | f.z);
      KIND_ULO:    cond_holds = f.c;
      default:     cond_holds = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/branch_eval_decode.sv
`timescale 1ns/1ps
module branch_eval_decode
  import branch_eval_pkg::*;
(
  input  logic [7:0] opb_i,
  output br_kind_e   kind_o,
  output logic       hit_o
);
  always_comb begin
    kind_o = kind_of(opb_i);
    hit_o  = (kind_o != KIND_NONE);
  end
endmodule

// File: rtl/branch_eval_cond.sv
`timescale 1ns/1ps
module branch_eval_cond
  import branch_eval_pkg::*;
(
  input  br_kind_e   kind_i,
  input  logic [3:0] flags_i,
  output logic       met_o
);
  ccodes_t cc;
  always_comb begin
    cc    = ccodes_t'(flags_i);
    met_o = cond_holds(kind_i, cc);
  end
endmodule

// File: rtl/branch_eval_target.sv
`timescale 1ns/1ps
module branch_eval_target #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [AW-1:0] seq_i,
  input  logic [OW-1:0] ofs_i,
  output logic [AW-1:0] dest_o
);
  localparam int EXT = AW - OW - 1;

  function automatic logic [AW-1:0] byte_disp(input logic [OW-1:0] ofs);
    byte_disp = {{EXT{ofs[OW-1]}}, ofs, 1'b0};
  endfunction

  always_comb dest_o = seq_i + byte_disp(ofs_i);
endmodule

// File: rtl/branch_eval.sv
`timescale 1ns/1ps
module branch_eval
  import branch_eval_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr_i,
  input  logic [AW-1:0] seq_pc_i,
  input  logic [FW-1:0] flags_i,
  output logic          taken_o,
  output logic          hit_o,
  output logic [AW-1:0] target_o
);
  localparam int OPB_LSB = OW;

  br_kind_e      kind_w;
  logic          hit_w;
  logic          met_w;
  logic [AW-1:0] dest_w;
  logic          taken_w;
  logic [AW-1:0] next_w;

  branch_eval_decode u_dec (
    .opb_i  (instr_i[OPB_LSB +: 8]),
    .kind_o (kind_w),
    .hit_o  (hit_w)
  );

  branch_eval_cond u_cond (
    .kind_i  (kind_w),
    .flags_i (flags_i),
    .met_o   (met_w)
  );

  branch_eval_target #(.AW(AW), .OW(OW)) u_tgt (
    .seq_i  (seq_pc_i),
    .ofs_i  (instr_i[OW-1:0]),
    .dest_o (dest_w)
  );

  always_comb begin
    taken_w = hit_w & met_w;
    next_w  = hit_w ? dest_w : seq_pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o  <= 1'b0;
      hit_o    <= 1'b0;
      target_o <= '0;
    end else begin
      taken_o  <= taken_w;
      hit_o    <= hit_w;
      target_o <= next_w;
    end
  end
endmodule

// File: rtl/branch_eval_chk.sv
`timescale 1ns/1ps
module branch_eval_chk #(
  parameter int AW = 16,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   instr_i,
  input logic [AW-1:0] seq_pc_i,
  input logic [FW-1:0] flags_i,
  input logic          taken_o,
  input logic          hit_o,
  input logic [AW-1:0] target_o
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> hit_o);

  assert_miss_falls_through_R2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !hit_o |-> (target_o == $past(seq_pc_i)));

  assert_always_taken_R3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(instr_i[15:8]) == 8'h01) |-> taken_o);

  assert_eq_follows_z_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(instr_i[15:8]) == 8'h03) |-> (taken_o == $past(flags_i[2])));

  assert_slt_follows_nv_R5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(instr_i[15:8]) == 8'h05) |-> (taken_o == $past(flags_i[3] ^ flags_i[1])));

  assert_ulo_follows_c_R6: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(instr_i[15:8]) == 8'h87) |-> (taken_o == $past(flags_i[0])));

  assert_target_parity_R7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    hit_o |-> (target_o[0] == $past(seq_pc_i[0])));

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(instr_i[15:8] == 8'h00) |-> !hit_o);
endmodule

bind branch_eval branch_eval_chk #(.AW(AW), .FW(FW)) u_chk (.*);

// File: tb/test_branch_eval.sv
`timescale 1ns/1ps
module test_branch_eval;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr_i;
  logic [15:0] seq_pc_i;
  logic [3:0]  flags_i;
  logic        taken_o;
  logic        hit_o;
  logic [15:0] target_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        hit;
    logic        taken;
    logic [15:0] tgt;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  branch_eval i_branch_eval (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .seq_pc_i(seq_pc_i),
    .flags_i(flags_i), .taken_o(taken_o), .hit_o(hit_o), .target_o(target_o)
  );

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] w, input logic [15:0] seq,
                                 input logic [3:0] f, input string tag);
    exp_t e;
    int off;
    logic n, z, v, c;
    {n, z, v, c} = f;
    e.tag = tag;
    e.hit = 1'b1;
    case (w[15:8])
      8'o001:  e.taken = 1'b1;
      8'o002:  e.taken = !z;
      8'o003:  e.taken = z;
      8'o005:  e.taken = (n != v);
      8'o006:  e.taken = !z && (n == v);
      8'o202:  e.taken = !c && !z;
      8'o207:  e.taken = c;
      default: begin e.hit = 1'b0; e.taken = 1'b0; end
    endcase
    off = (w[7:0] > 127) ? int'(w[7:0]) - 256 : int'(w[7:0]);
    e.tgt = e.hit ? 16'((int'(seq) + 2 * off) & 16'hFFFF) : seq;
    return e;
  endfunction

  function automatic logic [3:0] cmp_flags(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r;
    r = a - b;
    return {r[15], (r == 16'h0), (a[15] != b[15]) && (r[15] != a[15]), (a < b)};
  endfunction

  task automatic drive(input logic [15:0] w, input logic [15:0] seq,
                       input logic [3:0] f, input string tag);
    @(negedge clk);
    instr_i  = w;
    seq_pc_i = seq;
    flags_i  = f;
    sb.push_back(model(w, seq, f, tag));
  endtask

  // monitor: result appears one edge after the drive (R9)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check1(e.tag, "hit", int'(hit_o), int'(e.hit));
        check1(e.tag, "taken", int'(taken_o), int'(e.taken));
        check1(e.tag, "target", int'(target_o), int'(e.tgt));
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [7];
    ops = '{8'h01, 8'h02, 8'h03, 8'h05, 8'h06, 8'h82, 8'h87};
    rst_n    = 1'b0;
    instr_i  = 16'h01FF;
    seq_pc_i = 16'h1234;
    flags_i  = 4'hF;
    repeat (3) @(posedge clk);
    #2;
    check1("R1", "taken in reset", int'(taken_o), 0);
    check1("R1", "hit in reset", int'(hit_o), 0);
    check1("R1", "target in reset", int'(target_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 / R4 / R5 / R6: every kind against every flag nibble
    for (int k = 0; k < 7; k++)
      for (int f = 0; f < 16; f++)
        drive({ops[k], 8'h05}, 16'h2000, 4'(f), "R3_R4_R5_R6 flag sweep");

    // R2: unrecognised upper bytes
    drive(16'h0000, 16'h3000, 4'hF, "R2 zero word");
    drive(16'h0410, 16'h3000, 4'h0, "R2 byte 0x04");
    drive(16'h8012, 16'h3002, 4'h4, "R2 byte 0x80");
    drive(16'hFFFF, 16'h3004, 4'h1, "R2 byte 0xFF");
    drive(16'h8310, 16'h3006, 4'h1, "R2 byte 0x83");

    // R7: every offset, forward and backward
    for (int o = 0; o < 256; o++)
      drive({8'h01, 8'(o)}, 16'h4000, 4'h0, "R7 offset sweep");
    drive(16'h01FF, 16'h0802, 4'h0, "R7 self branch");

    // R8: wrap at both ends
    drive(16'h0101, 16'hFFFE, 4'h0, "R8 wrap up");
    drive(16'h01FE, 16'h0002, 4'h0, "R8 wrap down");
    drive(16'h017F, 16'hFF80, 4'h0, "R8 wrap max forward");

    // R5: flags from signed compares, lower vs higher
    begin
      logic [15:0] lo_s [6];
      logic [15:0] hi_s [6];
      lo_s = '{16'd0, 16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000, 16'hFFD6};
      hi_s = '{16'd1, 16'd0, 16'd1, 16'd32767, 16'd0, 16'hFFEF};
      for (int i = 0; i < 6; i++) begin
        drive(16'h0503, 16'h5000, cmp_flags(lo_s[i], hi_s[i]), "R5 signed lt");
        drive(16'h0603, 16'h5000, cmp_flags(hi_s[i], lo_s[i]), "R5 signed gt");
        drive(16'h0603, 16'h5000, cmp_flags(lo_s[i], hi_s[i]), "R5 signed gt not");
      end
    end

    // R6: flags from unsigned compares
    begin
      logic [15:0] lo_u [5];
      logic [15:0] hi_u [5];
      lo_u = '{16'd0, 16'd0, 16'd32768, 16'd65534, 16'd32767};
      hi_u = '{16'd1, 16'd65535, 16'd65535, 16'd65535, 16'd32768};
      for (int i = 0; i < 5; i++) begin
        drive(16'h8703, 16'h6000, cmp_flags(lo_u[i], hi_u[i]), "R6 unsigned lo");
        drive(16'h8203, 16'h6000, cmp_flags(hi_u[i], lo_u[i]), "R6 unsigned hi");
        drive(16'h8203, 16'h6000, cmp_flags(lo_u[i], lo_u[i]), "R6 unsigned hi equal");
      end
    end

    // R9: back-to-back random words, one result per edge
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 2 == 0) w[15:8] = ops[i % 7];
      drive(w, 16'($urandom) & 16'hFFFE, 4'($urandom), "R9 random stream");
    end

    repeat (4) @(posedge clk);
    #3;
    check1("R9", "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule